// File: doc/BRIEF.md
# Select-Coded Arithmetic-Logic Unit

This block is a purely combinational N-bit arithmetic-logic unit. It has two operands, a three-bit function select and a carry input. It returns an N-bit result and a carry output in the same cycle the inputs are applied. The top select bit picks between two groups of functions. When it is low, the unit does arithmetic and the carry input helps choose the function. When it is high, the unit does one of four bitwise logic functions and the carry input has no effect.

The arithmetic half is a single adder. Its second operand is zero, B, the complement of B, or all ones, chosen by the two low select bits. The carry input goes straight into the adder. This gives seven arithmetic functions: pass, increment, add, add with carry, subtract with borrow, subtract and decrement. Select 011 with carry 1 is a second pass code.

The adder is built from lookahead groups. The groups are chained by group-level generate and propagate terms. The width and the group size are parameters, with defaults of 8 and 4.

The function codes are named in the shared package:

| Code | Name |
|------|------|
| 000 | FN_PASS_INC |
| 001 | FN_ADD |
| 010 | FN_SUB_BRW |
| 011 | FN_DEC_PASS |
| 100 | FN_OR |
| 101 | FN_XOR |
| 110 | FN_AND |
| 111 | FN_NOT |

There are no states and no transitions.

Top module: `alu_sel_core`

## Requirements
- R1: Select 000 with carry-in 0 returns A with carry-out 0. With carry-in 1 it returns (A+1) mod 2^N, and carry-out is 1 exactly when A is all ones.
- R2: Select 001 returns (A+B+cin) mod 2^N, and carry-out is bit N of that sum.
- R3: Select 010 with carry-in 1 returns (A−B) mod 2^N, and carry-out is 1 exactly when A ≥ B unsigned. With carry-in 0 it returns (A−B−1) mod 2^N, and carry-out is 1 exactly when A > B unsigned.
- R4: Select 011 with carry-in 0 returns (A−1) mod 2^N, and carry-out is 1 exactly when A is nonzero. With carry-in 1 it returns A with carry-out 1.
- R5: Select 100 returns A OR B, and select 101 returns A XOR B.
- R6: Select 110 returns A AND B, and select 111 returns the bitwise complement of A.
- R7: For the four codes with select bit 2 set, carry-out is 0. Neither the result nor the carry-out depends on carry-in.
- R8: Carries cross lookahead group boundaries correctly. An all-ones operand plus one yields a zero result with carry-out 1. A low group that is all ones carries into the next group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| sel | input | 3 | Function select; bit 2 picks the logic group |
| cin | input | 1 | Carry input, part of the arithmetic function choice |
| y | output | N | Result |
| cout | output | 1 | Adder carry for arithmetic codes, 0 for logic codes |

## Verification
The block holds no state, so any fault shows on y or cout in the same cycle the inputs are applied. A wrong operand choice for B would turn one arithmetic code into another. For example, decrement would look like add, and this would appear on the very next vector for that code. A broken group carry only shows when a carry has to cross a group boundary, so operands that fill a whole low group with ones are applied on purpose. A carry input leaking into the logic path would show as results that differ between the two carry-in values under the same logic code.

// File: rtl/alu_sel_pkg.sv
package alu_sel_pkg;

    // Function codes; the code value is the select input itself.
    typedef enum logic [2:0] {
        FN_PASS_INC = 3'b000,
        FN_ADD      = 3'b001,
        FN_SUB_BRW  = 3'b010,
        FN_DEC_PASS = 3'b011,
        FN_OR       = 3'b100,
        FN_XOR      = 3'b101,
        FN_AND      = 3'b110,
        FN_NOT      = 3'b111
    } alu_fn_e;

    // Second-operand choice for the adder, indexed by the low select bits.
    typedef enum logic [1:0] {
        OPB_ZERO = 2'b00,
        OPB_TRUE = 2'b01,
        OPB_INV  = 2'b10,
        OPB_ONES = 2'b11
    } opb_sel_e;

endpackage

// File: rtl/alu_sel_opb.sv
module alu_sel_opb
    import alu_sel_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] b,
    input  logic [1:0]   pick,
    output logic [N-1:0] opb
);

    opb_sel_e pick_e;

    assign pick_e = opb_sel_e'(pick);

    always_comb begin
        unique case (pick_e)
            OPB_ZERO: opb = '0;
            OPB_TRUE: opb = b;
            OPB_INV:  opb = ~b;
            OPB_ONES: opb = '1;
            default:  opb = '0;
        endcase
    end

endmodule

// File: rtl/alu_sel_adder.sv
module alu_sel_adder #(
    parameter int N   = 8,
    parameter int GRP = 4
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    input  logic         ci,
    output logic [N-1:0] s,
    output logic         co
);

    localparam int NG = (N + GRP - 1) / GRP;

    logic [N-1:0] gen;
    logic [N-1:0] prp;
    logic [N:0]   cy;
    logic [NG:0]  gcy;

    assign gen    = x & y;
    assign prp    = x ^ y;
    assign gcy[0] = ci;

    for (genvar gi = 0; gi < NG; gi++) begin : g_grp
        localparam int LO = gi * GRP;
        localparam int W  = ((N - LO) < GRP) ? (N - LO) : GRP;

        logic grp_g;
        logic grp_p;

        // Group-level generate and propagate terms.
        always_comb begin
            grp_g = 1'b0;
            grp_p = 1'b1;
            for (int k = 0; k < W; k++) begin
                grp_g = gen[LO+k] | (prp[LO+k] & grp_g);
                grp_p = grp_p & prp[LO+k];
            end
        end

        // Carry into the next group comes from the group terms.
        assign gcy[gi+1] = grp_g | (grp_p & gcy[gi]);
        assign cy[LO]    = gcy[gi];

        for (genvar bi = 0; bi < W - 1; bi++) begin : g_bit
            assign cy[LO+bi+1] = gen[LO+bi] | (prp[LO+bi] & cy[LO+bi]);
        end
    end

    assign cy[N] = gcy[NG];
    assign s     = prp ^ cy[N-1:0];
    assign co    = cy[N];

endmodule

// File: rtl/alu_sel_logic.sv
module alu_sel_logic
    import alu_sel_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic [1:0]   pick,
    output logic [N-1:0] r
);

    always_comb begin
        unique case (pick)
            2'b00:   r = a | b;
            2'b01:   r = a ^ b;
            2'b10:   r = a & b;
            2'b11:   r = ~a;
            default: r = '0;
        endcase
    end

endmodule

// File: rtl/alu_sel_core.sv
module alu_sel_core
    import alu_sel_pkg::*;
#(
    parameter int N   = 8,
    parameter int GRP = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic [2:0]   sel,
    input  logic         cin,
    output logic [N-1:0] y,
    output logic         cout
);

    alu_fn_e      fn;
    logic [N-1:0] opb;
    logic [N-1:0] sum;
    logic         sum_co;
    logic [N-1:0] lres;

    assign fn = alu_fn_e'(sel);

    alu_sel_opb #(.N(N)) u_opb (
        .b    (b),
        .pick (sel[1:0]),
        .opb  (opb)
    );

    alu_sel_adder #(.N(N), .GRP(GRP)) u_add (
        .x  (a),
        .y  (opb),
        .ci (cin),
        .s  (sum),
        .co (sum_co)
    );

    alu_sel_logic #(.N(N)) u_log (
        .a    (a),
        .b    (b),
        .pick (sel[1:0]),
        .r    (lres)
    );

    always_comb begin
        unique case (fn)
            FN_PASS_INC, FN_ADD, FN_SUB_BRW, FN_DEC_PASS: begin
                y    = sum;
                cout = sum_co;
            end
            FN_OR, FN_XOR, FN_AND, FN_NOT: begin
                y    = lres;
                cout = 1'b0;
            end
            default: begin
                y    = '0;
                cout = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu_sel_chk.sv
module alu_sel_chk #(
    parameter int N = 8
) (
    input logic [N-1:0] a,
    input logic [N-1:0] b,
    input logic [2:0]   sel,
    input logic         cin,
    input logic [N-1:0] y,
    input logic         cout
);

    always_comb begin
        // R7
        if (sel[2]) begin
            logic_cout_chk: assert (cout == 1'b0);
        end
        // R1
        if (sel == 3'b000 && !cin) begin
            pass_lo_chk: assert (y == a && !cout);
        end
        // R4
        if (sel == 3'b011 && cin) begin
            dec_pass_chk: assert (y == a && cout);
        end
        // R3
        if (sel == 3'b010 && cin) begin
            sub_cmp_chk: assert (cout == (a >= b));
        end
        // R6
        if (sel == 3'b111) begin
            not_a_chk: assert (y == ~a);
        end
    end

endmodule

bind alu_sel_core alu_sel_chk #(.N(N)) u_chk (
    .a    (a),
    .b    (b),
    .sel  (sel),
    .cin  (cin),
    .y    (y),
    .cout (cout)
);

// File: tb/test_alu_sel_core.sv
module test_alu_sel_core;

    localparam int N = 8;
    localparam logic [N-1:0] ONES = '1;

    logic clk = 1'b0;
    logic [N-1:0] a = '0;
    logic [N-1:0] b = '0;
    logic [2:0]   sel = '0;
    logic         cin = 1'b0;
    logic [N-1:0] y;
    logic         cout;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    alu_sel_core #(.N(N), .GRP(4)) i_alu_sel_core (
        .a(a), .b(b), .sel(sel), .cin(cin), .y(y), .cout(cout)
    );

    function automatic logic [N:0] model(input logic [N-1:0] x, input logic [N-1:0] z,
                                         input logic [2:0] s, input logic c);
        logic [N:0] w;
        case (s)
            3'b000: w = c ? {x == ONES, x + 1'b1} : {1'b0, x};
            3'b001: w = {1'b0, x} + {1'b0, z} + {{N{1'b0}}, c};
            3'b010: w = c ? {x >= z, x - z} : {x > z, x - z - 1'b1};
            3'b011: w = c ? {1'b1, x} : {x != '0, x - 1'b1};
            3'b100: w = {1'b0, x | z};
            3'b101: w = {1'b0, x ^ z};
            3'b110: w = {1'b0, x & z};
            default: w = {1'b0, ~x};
        endcase
        return w;
    endfunction

    function automatic string tag(input logic [2:0] s);
        case (s)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b011: return "R4";
            3'b100, 3'b101: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [N:0] got, input logic [N:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: a=%h b=%h sel=%b cin=%b actual=%h expected=%h",
                     req, a, b, sel, cin, got, exp);
        end
    endtask

    task automatic apply(input logic [N-1:0] x, input logic [N-1:0] z,
                         input logic [2:0] s, input logic c, input string req);
        logic [N:0] e;
        @(posedge clk);
        a = x; b = z; sel = s; cin = c;
        @(negedge clk);
        e = model(x, z, s, c);
        check(req == "" ? tag(s) : req, {1'b0, y}, {1'b0, e[N-1:0]});
        // R7: logic codes give carry 0 whatever cin is
        check(s[2] ? "R7" : (req == "" ? tag(s) : req), {{N{1'b0}}, cout}, {{N{1'b0}}, e[N]});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] edges [5];
        int unused_seed;
        edges[0] = '0; edges[1] = 8'h01; edges[2] = ONES;
        edges[3] = 8'h80; edges[4] = 8'h7F;
        unused_seed = $urandom(32'h1234_5678);

        // Idle state: all-zero inputs give zero outputs (R1)
        @(negedge clk);
        check("R1", {1'b0, y}, '0);
        check("R1", {{N{1'b0}}, cout}, '0);

        // R8: carries across group boundaries
        apply(8'h0F, 8'h01, 3'b001, 1'b0, "R8");
        apply(ONES, 8'h01, 3'b001, 1'b0, "R8");
        apply(ONES, 8'h00, 3'b000, 1'b1, "R8");
        apply(8'h10, 8'h00, 3'b011, 1'b0, "R8");
        apply(8'h0E, 8'h00, 3'b001, 1'b1, "R8");

        // R4: cin flips decrement into pass
        apply(8'h00, 8'h55, 3'b011, 1'b0, "R4");
        apply(8'h00, 8'h55, 3'b011, 1'b1, "R4");
        // R3: equal operands, both borrow forms
        apply(8'h3C, 8'h3C, 3'b010, 1'b1, "R3");
        apply(8'h3C, 8'h3C, 3'b010, 1'b0, "R3");

        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 2; c++) begin
                for (int i = 0; i < 5; i++)
                    for (int j = 0; j < 5; j++)
                        apply(edges[i], edges[j], 3'(s), 1'(c), "");
                for (int r = 0; r < 40; r++)
                    apply(N'($urandom), N'($urandom), 3'(s), 1'(c), "");
            end
        end

        // R7: same logic inputs under both cin values must match
        for (int s = 4; s < 8; s++) begin
            logic [N-1:0] y0;
            logic [N-1:0] tx;
            logic [N-1:0] tz;
            tx = N'($urandom);
            tz = N'($urandom);
            apply(tx, tz, 3'(s), 1'b0, "R7");
            y0 = y;
            apply(tx, tz, 3'(s), 1'b1, "R7");
            check("R7", {1'b0, y}, {1'b0, y0});
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule